// File: doc/BRIEF.md
# Vector Permute-Control Mask Generator

This block turns one shift-mask instruction into the byte-selector vector that a two-source byte permute unit needs to realign an unaligned 16-byte quantity. It decodes a 32-bit instruction word in either of two layouts: a classic X-form with a 5-bit destination, or an extended form whose 7-bit destination is split across two fields and addresses v0 to v127. It adds the two 64-bit general-purpose register values that the issue stage supplies, with an RA field of zero selecting a constant zero base. Only the low four bits of that sum are kept, as the misalignment `sh`.

From `sh` the block builds sixteen byte lanes. The left variant counts upward from `sh`. The right variant counts upward from `16 - sh`. The lanes are not wrapped modulo 16, so selectors above 15 pick bytes from the second permute source. The block reads no memory and changes no flags. Its only product is a register write of the mask, with its destination number and write enable, one cycle after the valid strobe. A word that matches neither layout and variant produces no write and raises an illegal-instruction flag instead.

Top module: `pmask_gen`

## Requirements
- R1: In the X-form, with instruction bit 0 taken as the MSB (port bit 31), a word is legal when bits 0-5 equal 31, bit 31 (port bit 0) is 0, and bits 21-30 equal 6 for the left variant or 38 for the right variant. The destination is bits 6-10, zero-extended to 7 bits.
- R2: In the extended form, a word is legal when bits 0-5 equal 4 and bits 21-27 equal 3 for the left variant or 67 for the right variant. Bits 30-31 are ignored. The destination is {bits 28-29, bits 6-10}, so it ranges from 0 to 127.
- R3: When the RA field (bits 11-15) is 0, the base is the constant zero, whatever the value on `ra_val`.
- R4: The shift amount `sh` is the low 4 bits of the 64-bit sum of the base and `rb_val`. Carries into and beyond bit 4 have no effect.
- R5: For the left variant, byte lane i (i = 0..15) equals sh + i with no reduction. Lane 0 is bits 127:120. With sh = 0 the lanes read 0,1,...,15.
- R6: For the right variant, byte lane i equals 16 - sh + i. With sh = 0 the lanes read 16..31, and with sh = 15 they read 1..16.
- R7: A valid, unrecognised word gives `out_we` = 0 and `out_illegal` = 1 on the next cycle, and `out_vd` and `out_mask` keep their previous values.
- R8: All outputs are registered. A legal strobe shows on the cycle after it, and a cycle without `in_valid` gives `out_we` = 0 and `out_illegal` = 0 on the next cycle.
- R9: Synchronous active-high reset clears `out_we`, `out_illegal`, `out_vd` and `out_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| in_insn | input | 32 | Instruction word; port bit 31 is instruction bit 0 |
| ra_val | input | 64 | Contents of the register named by RA |
| rb_val | input | 64 | Contents of the register named by RB |
| out_we | output | 1 | Vector register write enable |
| out_vd | output | 7 | Destination vector register number |
| out_mask | output | 128 | Byte-selector vector, lane 0 in bits 127:120 |
| out_illegal | output | 1 | Unrecognised instruction seen on the previous cycle |

## Verification
The block keeps no state beyond its single output register stage. Any decode or arithmetic fault therefore appears at the ports exactly one cycle after the strobe that exposes it, and the next strobe overwrites it. A wrong `sh` shifts every lane by the same amount, which the lane-0 value shows at once. A broken lane generator breaks the step of one between neighbouring lanes. A misdecoded field shows up as a wrong destination number, a missing write, or a spurious illegal flag on that same cycle. The stimulus therefore pairs each decode path with operands whose low nibbles and carries differ, so that each fault moves a port value.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

  localparam int INSN_W = 32;
  localparam int VD_W   = 7;

  localparam logic [5:0] OPC_XFORM = 6'd31;
  localparam logic [5:0] OPC_WIDE  = 6'd4;

  localparam logic [9:0] XO_X_LEFT  = 10'd6;
  localparam logic [9:0] XO_X_RIGHT = 10'd38;
  localparam logic [6:0] XO_W_LEFT  = 7'd3;
  localparam logic [6:0] XO_W_RIGHT = 7'd67;

  typedef enum logic [1:0] {
    DIR_NONE  = 2'd0,
    DIR_LEFT  = 2'd1,
    DIR_RIGHT = 2'd2
  } dir_e;

  typedef struct packed {
    logic            legal;
    dir_e            dir;
    logic [VD_W-1:0] vd;
    logic            ra_zero;
  } dec_t;

endpackage

// File: rtl/pmask_decode.sv
module pmask_decode
  import pmask_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);

  // Instruction bit k (k = 0 is the MSB) sits on port bit 31-k.
  logic [5:0] f_opc;
  logic [4:0] f_vd_lo;
  logic [4:0] f_ra;
  logic [9:0] f_xo_x;
  logic       f_rc;
  logic [6:0] f_xo_w;
  logic [1:0] f_vd_hi;
  logic       x_hit;
  logic       w_hit;
  logic       unused_fields;

  assign f_opc   = insn[31:26];
  assign f_vd_lo = insn[25:21];
  assign f_ra    = insn[20:16];
  assign f_xo_x  = insn[10:1];
  assign f_rc    = insn[0];
  assign f_xo_w  = insn[10:4];
  assign f_vd_hi = insn[3:2];

  // RB register number is resolved by the issue stage; only its value arrives.
  assign unused_fields = ^insn[15:11];

  assign x_hit = (f_opc == OPC_XFORM) && !f_rc;
  assign w_hit = (f_opc == OPC_WIDE);

  always_comb begin
    dec         = '0;
    dec.dir     = DIR_NONE;
    dec.ra_zero = (f_ra == 5'd0);
    if (x_hit) begin
      dec.vd = {2'b00, f_vd_lo};
      if (f_xo_x == XO_X_LEFT) begin
        dec.legal = 1'b1;
        dec.dir   = DIR_LEFT;
      end else if (f_xo_x == XO_X_RIGHT) begin
        dec.legal = 1'b1;
        dec.dir   = DIR_RIGHT;
      end
    end else if (w_hit) begin
      dec.vd = {f_vd_hi, f_vd_lo};
      if (f_xo_w == XO_W_LEFT) begin
        dec.legal = 1'b1;
        dec.dir   = DIR_LEFT;
      end else if (f_xo_w == XO_W_RIGHT) begin
        dec.legal = 1'b1;
        dec.dir   = DIR_RIGHT;
      end
    end
  end

endmodule

// File: rtl/pmask_ea_low.sv
module pmask_ea_low #(
  parameter int GPR_W = 64,
  parameter int SH_W  = 4
) (
  input  logic             ra_zero,
  input  logic [GPR_W-1:0] ra_val,
  input  logic [GPR_W-1:0] rb_val,
  output logic [SH_W-1:0]  sh
);

  logic [GPR_W-1:0] base;
  logic             unused_upper;

  assign base = ra_zero ? '0 : ra_val;

  // Carries only propagate upward, so the low nibble of the full sum
  // equals the sum of the low nibbles.
  assign sh = base[SH_W-1:0] + rb_val[SH_W-1:0];

  assign unused_upper = ^{base[GPR_W-1:SH_W], rb_val[GPR_W-1:SH_W]};

endmodule

// File: rtl/pmask_lanes.sv
module pmask_lanes #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8,
  parameter int SH_W   = $clog2(LANES)
) (
  input  logic [SH_W-1:0]         sh,
  input  logic                    right,
  output logic [LANES*LANE_W-1:0] mask
);

  logic [LANE_W-1:0] start;

  assign start = right ? (LANE_W'(LANES) - LANE_W'(sh)) : LANE_W'(sh);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[(LANES-1-i)*LANE_W +: LANE_W] = start + LANE_W'(i);
  end

endmodule

// File: rtl/pmask_gen.sv
module pmask_gen
  import pmask_pkg::*;
#(
  parameter int GPR_W  = 64,
  parameter int LANES  = 16,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [INSN_W-1:0]       in_insn,
  input  logic [GPR_W-1:0]        ra_val,
  input  logic [GPR_W-1:0]        rb_val,
  output logic                    out_we,
  output logic [VD_W-1:0]         out_vd,
  output logic [LANES*LANE_W-1:0] out_mask,
  output logic                    out_illegal
);

  localparam int SH_W   = $clog2(LANES);
  localparam int MASK_W = LANES * LANE_W;

  dec_t              dec;
  logic [SH_W-1:0]   sh;
  logic [MASK_W-1:0] mask_c;

  pmask_decode u_decode (
    .insn (in_insn),
    .dec  (dec)
  );

  pmask_ea_low #(
    .GPR_W (GPR_W),
    .SH_W  (SH_W)
  ) u_ea (
    .ra_zero (dec.ra_zero),
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .sh      (sh)
  );

  pmask_lanes #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .SH_W   (SH_W)
  ) u_lanes (
    .sh    (sh),
    .right (dec.dir == DIR_RIGHT),
    .mask  (mask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_we      <= 1'b0;
      out_illegal <= 1'b0;
      out_vd      <= '0;
      out_mask    <= '0;
    end else begin
      out_we      <= in_valid && dec.legal;
      out_illegal <= in_valid && !dec.legal;
      if (in_valid && dec.legal) begin
        out_vd   <= dec.vd;
        out_mask <= mask_c;
      end
    end
  end

endmodule

// File: rtl/pmask_gen_chk.sv
module pmask_gen_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [31:0]  in_insn,
  input logic [63:0]  rb_val,
  input logic         out_we,
  input logic [6:0]   out_vd,
  input logic [127:0] out_mask,
  input logic         out_illegal
);

  p_we_ill_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(out_we && out_illegal));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_we && !out_illegal));

  p_hold_on_illegal_r7: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> ($stable(out_mask) && $stable(out_vd)));

  p_lane0_range_r6: assert property (@(posedge clk) disable iff (rst)
    out_we |-> (out_mask[127:120] <= 8'd16));

  // Left X-form with RA field 0: lane 0 comes from RB alone.
  p_ra_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insn[31:26] == 6'd31 && in_insn[20:16] == 5'd0 &&
     in_insn[10:1] == 10'd6 && !in_insn[0])
    |=> (out_we && out_mask[127:120] == {4'b0000, $past(rb_val[3:0])}));

  p_vd_fuse_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insn[31:26] == 6'd4 && in_insn[10:4] == 7'd3)
    |=> (out_we && out_vd == $past({in_insn[3:2], in_insn[25:21]})));

  for (genvar i = 0; i < 15; i++) begin : g_step
    p_lane_step_r5: assert property (@(posedge clk) disable iff (rst)
      out_we |-> (out_mask[(14-i)*8 +: 8] == out_mask[(15-i)*8 +: 8] + 8'd1));
  end

endmodule

bind pmask_gen pmask_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_insn     (in_insn),
  .rb_val      (rb_val),
  .out_we      (out_we),
  .out_vd      (out_vd),
  .out_mask    (out_mask),
  .out_illegal (out_illegal)
);

// File: tb/pmask_gen_tb.sv
module pmask_gen_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  in_insn = '0;
  logic [63:0]  ra_val = '0;
  logic [63:0]  rb_val = '0;
  logic         out_we;
  logic [6:0]   out_vd;
  logic [127:0] out_mask;
  logic         out_illegal;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pmask_gen u_dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_insn     (in_insn),
    .ra_val      (ra_val),
    .rb_val      (rb_val),
    .out_we      (out_we),
    .out_vd      (out_vd),
    .out_mask    (out_mask),
    .out_illegal (out_illegal)
  );

  function automatic logic [31:0] enc_x(input logic [9:0] xo, input logic [4:0] vd,
                                        input logic [4:0] ra, input logic rc);
    return {6'd31, vd, ra, 5'd9, xo, rc};
  endfunction

  function automatic logic [31:0] enc_w(input logic [6:0] xo, input logic [6:0] vd,
                                        input logic [4:0] ra);
    return {6'd4, vd[4:0], ra, 5'd12, xo, vd[6:5], 2'b00};
  endfunction

  function automatic logic [127:0] exp_mask(input logic right, input logic [3:0] sh);
    logic [127:0] r;
    for (int i = 0; i < 16; i++)
      r[(15-i)*8 +: 8] = right ? 8'(16 - int'(sh) + i) : 8'(int'(sh) + i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; ra_val = a; rb_val = b;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic expect_write(input string req, input logic [6:0] vd,
                              input logic right, input logic [3:0] sh);
    chk({req, " we"}, 128'(out_we), 128'(1));
    chk({req, " illegal"}, 128'(out_illegal), 128'(0));
    chk({req, " vd"}, 128'(out_vd), 128'(vd));
    chk({req, " mask"}, out_mask, exp_mask(right, sh));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 we", 128'(out_we), 128'(0));
    chk("R9 illegal", 128'(out_illegal), 128'(0));
    chk("R9 vd", 128'(out_vd), 128'(0));
    chk("R9 mask", out_mask, 128'(0));
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_x_left();
    issue(enc_x(10'd6, 5'd3, 5'd1, 1'b0), 64'h10, 64'h0);
    expect_write("R1 R5 sh0", 7'd3, 1'b0, 4'd0);
    issue(enc_x(10'd6, 5'd31, 5'd2, 1'b0), 64'h1001, 64'h2);
    expect_write("R1 R5 sh3", 7'd31, 1'b0, 4'd3);
    issue(enc_x(10'd6, 5'd17, 5'd2, 1'b0), 64'h7, 64'h8);
    expect_write("R5 sh15", 7'd17, 1'b0, 4'd15);
  endtask

  task automatic t_x_right();
    issue(enc_x(10'd38, 5'd5, 5'd4, 1'b0), 64'h20, 64'h0);
    expect_write("R6 sh0", 7'd5, 1'b1, 4'd0);
    issue(enc_x(10'd38, 5'd6, 5'd4, 1'b0), 64'h0, 64'hF);
    expect_write("R6 sh15", 7'd6, 1'b1, 4'd15);
    issue(enc_x(10'd38, 5'd7, 5'd4, 1'b0), 64'h5, 64'h0);
    expect_write("R6 sh5", 7'd7, 1'b1, 4'd5);
  endtask

  task automatic t_ra_zero();
    issue(enc_x(10'd6, 5'd8, 5'd0, 1'b0), 64'h7, 64'h4);
    expect_write("R3 left", 7'd8, 1'b0, 4'd4);
    issue(enc_w(7'd67, 7'd90, 5'd0), 64'hB, 64'h2);
    expect_write("R3 wide right", 7'd90, 1'b1, 4'd2);
  endtask

  task automatic t_carry();
    issue(enc_x(10'd6, 5'd9, 5'd3, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    expect_write("R4 full carry", 7'd9, 1'b0, 4'd0);
    issue(enc_x(10'd6, 5'd10, 5'd3, 1'b0), 64'h1234_5678_9ABC_DEF9, 64'h8000_0000_0000_000A);
    expect_write("R4 nibble carry", 7'd10, 1'b0, 4'd3);
  endtask

  task automatic t_wide();
    issue(enc_w(7'd3, 7'd127, 5'd1), 64'h4, 64'h0);
    expect_write("R2 vd127", 7'd127, 1'b0, 4'd4);
    issue(enc_w(7'd3, 7'd64, 5'd1), 64'h0, 64'h9);
    expect_write("R2 vd64", 7'd64, 1'b0, 4'd9);
    issue(enc_w(7'd67, 7'd33, 5'd1), 64'hC, 64'h0);
    expect_write("R2 right vd33", 7'd33, 1'b1, 4'd12);
    issue(enc_w(7'd3, 7'd96, 5'd1), 64'h1, 64'h0) ;
    expect_write("R2 vd96", 7'd96, 1'b0, 4'd1);
    issue(enc_w(7'd3, 7'd96, 5'd1) | 32'h3, 64'h2, 64'h0);
    expect_write("R2 reserved ignored", 7'd96, 1'b0, 4'd2);
  endtask

  task automatic t_illegal();
    logic [127:0] held;
    issue(enc_x(10'd6, 5'd11, 5'd1, 1'b0), 64'h6, 64'h0);
    expect_write("R7 setup", 7'd11, 1'b0, 4'd6);
    held = out_mask;
    issue(enc_x(10'd6, 5'd12, 5'd1, 1'b1), 64'h2, 64'h0);
    chk("R7 R1 rc set we", 128'(out_we), 128'(0));
    chk("R7 rc set illegal", 128'(out_illegal), 128'(1));
    issue(enc_x(10'd7, 5'd12, 5'd1, 1'b0), 64'h2, 64'h0);
    chk("R7 bad xo illegal", 128'(out_illegal), 128'(1));
    issue(enc_w(7'd4, 7'd100, 5'd1), 64'h2, 64'h0);
    chk("R7 bad wide xo we", 128'(out_we), 128'(0));
    issue({6'd5, 26'h0000_00C}, 64'h2, 64'h0);
    chk("R7 bad opcode illegal", 128'(out_illegal), 128'(1));
    chk("R7 mask held", out_mask, held);
    chk("R7 vd held", 128'(out_vd), 128'(11));
  endtask

  task automatic t_timing();
    idle();
    chk("R8 idle we", 128'(out_we), 128'(0));
    chk("R8 idle illegal", 128'(out_illegal), 128'(0));
    @(negedge clk);
    in_valid = 1'b1; in_insn = enc_x(10'd6, 5'd13, 5'd1, 1'b0); ra_val = 64'hE; rb_val = 64'h0;
    #1;
    chk("R8 no early we", 128'(out_we), 128'(0));
    @(posedge clk); #1;
    expect_write("R8 next cycle", 7'd13, 1'b0, 4'd14);
    idle();
    chk("R8 drop we", 128'(out_we), 128'(0));
  endtask

  task automatic t_reset_mid();
    issue(enc_x(10'd38, 5'd14, 5'd1, 1'b0), 64'h3, 64'h0);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    chk("R9 mid we", 128'(out_we), 128'(0));
    chk("R9 mid mask", out_mask, 128'(0));
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_x_left();
    t_x_right();
    t_ra_zero();
    t_carry();
    t_wide();
    t_illegal();
    t_timing();
    t_reset_mid();
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule